// File: doc/BRIEF.md
# Per-Core Lazy Conflict Victim Tracker

This block sits beside one core's private cache in a small cluster that runs transactions with lazy versioning and lazy conflict resolution. While a transaction runs, it records which other cores hold uncommitted writes that clash with this transaction. It keeps that record as one bit per core, called the kill map. It also marks each cache slot that was read speculatively and is known to be written by another core. These slot marks are the read-conflict bits.

A committing core sends only one commit broadcast that carries its core number. Every tracker whose kill map holds that core's bit aborts. On that abort it hands the cache a mask of the slots to invalidate and wipes its own state. No write set is ever broadcast.

A core that earlier told others of a write conflict asks for an abort message when it aborts. The other trackers then drop its bit. A marked slot may be evicted and later brought back in the same transaction. To cover that case, evicted marked addresses go into a small Bloom filter, and a transactional allocation that hits the filter is marked again, without further checks.

Top module: `kill_tracker`

## Requirements
- R1: When `snp_valid` and `in_txn` are high, each set bit of `wconf_vec` (bit k = core k) sets bit k of `kmap_o` one cycle later. The bit of the block's own core (`CORE_ID`) is never set.
- R2: A snoop as in R1 with `snp_read` high and at least one foreign bit of `wconf_vec` set sets read-conflict bit `snp_slot` of `rconf_o`. A write snoop (`snp_read` low) sets no read-conflict bit.
- R3: A broadcast with `bc_valid` high and `bc_commit` low (abort message) from core `bc_core` clears that bit of `kmap_o`. A conflict recorded for the same core in the same cycle wins and leaves the bit set. A broadcast carrying the block's own core number is ignored.
- R4: A commit broadcast (`bc_commit` high) from a foreign core whose `kmap_o` bit is set raises `abort_o` for exactly one cycle, in the next cycle. A commit from an unmarked core, or carrying the own core number, raises nothing.
- R5: In the abort cycle, `inval_o` equals the read-conflict bits held before the commit broadcast; at all other times it is zero. The kill map, the read-conflict bits, the Bloom filter and the conflict-sent flag are all cleared.
- R6: `own_commit` clears the kill map, the read-conflict bits, the filter and the conflict-sent flag without raising `abort_o`. If a killing commit broadcast arrives in the same cycle, the abort of R4/R5 takes place instead.
- R7: `abort_msg_o` rises together with `abort_o` exactly when `sent_wconf` has been high at least once since the last clear, counting the cycle of the killing broadcast.
- R8: An eviction (`evict_valid`) of a slot whose read-conflict bit is set inserts `evict_addr` into the filter and clears that bit. An eviction of an unmarked slot only clears nothing and inserts nothing.
- R9: The filter is `BF_BITS`=256 bits and is indexed by two 8-bit hashes of the 16-bit address. h0 = addr[15:8] xor addr[7:0]. h1 = addr[7:0] xor (addr[15:8] rotated left by 1). An allocation (`alloc_valid` with `in_txn` high) whose two hash bits are both set sets read-conflict bit `alloc_slot`. An allocation outside a transaction has no effect.
- R10: After reset, `kmap_o`, `rconf_o`, `inval_o`, `abort_o` and `abort_msg_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_txn | input | 1 | This core is running a transaction |
| snp_valid | input | 1 | Response to this core's transactional snoop is present |
| snp_read | input | 1 | That snoop was a read (0 = write) |
| snp_slot | input | 4 | Cache slot of the snooped line |
| wconf_vec | input | 4 | Per-core write-conflict indication in the response |
| sent_wconf | input | 1 | This core signalled a write conflict to another core |
| bc_valid | input | 1 | A commit or abort broadcast is seen |
| bc_commit | input | 1 | Broadcast kind: 1 commit, 0 abort message |
| bc_core | input | 2 | Core number of the broadcaster |
| own_commit | input | 1 | This core commits its transaction |
| evict_valid | input | 1 | A slot is evicted |
| evict_slot | input | 4 | Evicted slot |
| evict_addr | input | 16 | Line address of the evicted slot |
| alloc_valid | input | 1 | A slot is allocated |
| alloc_slot | input | 4 | Allocated slot |
| alloc_addr | input | 16 | Line address being allocated |
| abort_o | output | 1 | One-cycle abort pulse |
| abort_msg_o | output | 1 | Request to broadcast an abort message |
| inval_o | output | 16 | Slots to invalidate, valid with abort_o |
| kmap_o | output | 4 | Current kill map |
| rconf_o | output | 16 | Current read-conflict bits |

## Verification
A directed run first replays the two-readers-one-writer case. In it, a read snoop marks the writer and the slot, and the writer's commit aborts the tracker with that slot in the mask. That run tells a working kill path apart from one that ignores the slot mark. Directed steps then put a conflict and an abort message for the same core in one cycle, a commit together with a killing broadcast, broadcasts from the own core number, and an evict-then-reallocate of a marked line. Each of these settles one priority rule. A long random phase then mixes snoops, broadcasts, evictions and allocations over a small pool of addresses, so that filter hits, false hits and misses all occur. It is compared against a behavioural model on every cycle, which shows up wrong ordering among clears, sets and inserts.

// File: rtl/kt_pkg.sv
package kt_pkg;
   // kind of broadcast seen on the snoop side
   typedef enum logic {
      BC_ABORT_MSG = 1'b0,
      BC_COMMIT    = 1'b1
   } bc_kind_e;
endpackage

// File: rtl/kt_map.sv
module kt_map #(
   parameter int NCORES  = 4,
   parameter int CORE_ID = 0,
   localparam int CID_W  = $clog2(NCORES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic [NCORES-1:0] set_vec,
   input  logic              drop_valid,
   input  logic [CID_W-1:0]  drop_core,
   input  logic              wconf_sent,
   output logic [NCORES-1:0] map_q,
   output logic              sticky_q
);
   localparam logic [NCORES-1:0] SELF = NCORES'(1) << CORE_ID;

   logic [NCORES-1:0] drop_mask;
   logic [NCORES-1:0] map_d;

   always_comb begin
      drop_mask = '0;
      if (drop_valid) drop_mask[drop_core] = 1'b1;
      // a fresh conflict wins over a same-cycle abort message
      map_d = ((map_q & ~drop_mask) | set_vec) & ~SELF;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         map_q    <= '0;
         sticky_q <= 1'b0;
      end else if (clear) begin
         map_q    <= '0;
         sticky_q <= 1'b0;
      end else begin
         map_q    <= map_d;
         sticky_q <= sticky_q | wconf_sent;
      end
   end
endmodule

// File: rtl/kt_rconf.sv
module kt_rconf #(
   parameter int NLINES = 16,
   localparam int SLOT_W = $clog2(NLINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              ev_valid,
   input  logic [SLOT_W-1:0] ev_slot,
   input  logic              snp_set,
   input  logic [SLOT_W-1:0] snp_slot,
   input  logic              al_set,
   input  logic [SLOT_W-1:0] al_slot,
   output logic [NLINES-1:0] bits_q
);
   logic [NLINES-1:0] bits_d;

   always_comb begin
      bits_d = bits_q;
      if (ev_valid) bits_d[ev_slot]  = 1'b0;
      if (snp_set)  bits_d[snp_slot] = 1'b1;
      if (al_set)   bits_d[al_slot]  = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     bits_q <= '0;
      else if (clear) bits_q <= '0;
      else            bits_q <= bits_d;
   end
endmodule

// File: rtl/kt_bloom.sv
module kt_bloom #(
   parameter int ADDR_W = 16,
   parameter int BITS   = 256,
   parameter int NHASH  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              ins_valid,
   input  logic [ADDR_W-1:0] ins_addr,
   input  logic [ADDR_W-1:0] q_addr,
   output logic              q_hit
);
   localparam int HW  = $clog2(BITS);
   localparam int NSL = ADDR_W / HW;

   // fold address slices; with rot set, slice j is rotated left by j
   function automatic logic [HW-1:0] fold(input logic [ADDR_W-1:0] a, input logic rot);
      logic [HW-1:0] h;
      logic [HW-1:0] s;
      int r;
      h = '0;
      for (int j = 0; j < NSL; j++) begin
         s = a[j*HW +: HW];
         r = rot ? (j % HW) : 0;
         if (r != 0) s = (s << r) | (s >> (HW - r));
         h ^= s;
      end
      return h;
   endfunction

   logic [BITS-1:0] filt_q;
   logic [HW-1:0]   qh0, qh1, ih0, ih1;

   assign qh0 = fold(q_addr, 1'b0);
   assign qh1 = fold(q_addr, 1'b1);
   assign ih0 = fold(ins_addr, 1'b0);
   assign ih1 = fold(ins_addr, 1'b1);

   generate
      if (NHASH == 2) begin : g_two
         assign q_hit = filt_q[qh0] & filt_q[qh1];
         always_ff @(posedge clk) begin
            if (!rst_n)     filt_q <= '0;
            else if (clear) filt_q <= '0;
            else if (ins_valid) begin
               filt_q[ih0] <= 1'b1;
               filt_q[ih1] <= 1'b1;
            end
         end
      end else begin : g_one
         assign q_hit = filt_q[qh0];
         always_ff @(posedge clk) begin
            if (!rst_n)         filt_q <= '0;
            else if (clear)     filt_q <= '0;
            else if (ins_valid) filt_q[ih0] <= 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/kill_tracker.sv
module kill_tracker #(
   parameter int NCORES  = 4,
   parameter int CORE_ID = 0,
   parameter int NLINES  = 16,
   parameter int ADDR_W  = 16,
   parameter int BF_BITS = 256,
   parameter int NHASH   = 2,
   localparam int CID_W  = $clog2(NCORES),
   localparam int SLOT_W = $clog2(NLINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_txn,
   input  logic              snp_valid,
   input  logic              snp_read,
   input  logic [SLOT_W-1:0] snp_slot,
   input  logic [NCORES-1:0] wconf_vec,
   input  logic              sent_wconf,
   input  logic              bc_valid,
   input  logic              bc_commit,
   input  logic [CID_W-1:0]  bc_core,
   input  logic              own_commit,
   input  logic              evict_valid,
   input  logic [SLOT_W-1:0] evict_slot,
   input  logic [ADDR_W-1:0] evict_addr,
   input  logic              alloc_valid,
   input  logic [SLOT_W-1:0] alloc_slot,
   input  logic [ADDR_W-1:0] alloc_addr,
   output logic              abort_o,
   output logic              abort_msg_o,
   output logic [NLINES-1:0] inval_o,
   output logic [NCORES-1:0] kmap_o,
   output logic [NLINES-1:0] rconf_o
);
   import kt_pkg::*;

   localparam logic [CID_W-1:0]  SELF_ID   = CID_W'(CORE_ID);
   localparam logic [NCORES-1:0] SELF_MASK = NCORES'(1) << CORE_ID;

   initial begin
      assert (NCORES >= 2 && (1 << CID_W) == NCORES) else $error("NCORES must be a power of two");
      assert (CORE_ID < NCORES) else $error("CORE_ID out of range");
      assert ((1 << SLOT_W) == NLINES) else $error("NLINES must be a power of two");
      assert ((1 << $clog2(BF_BITS)) == BF_BITS) else $error("BF_BITS must be a power of two");
      assert (ADDR_W % $clog2(BF_BITS) == 0) else $error("ADDR_W must be a multiple of the hash width");
      assert (NHASH == 1 || NHASH == 2) else $error("NHASH must be 1 or 2");
   end

   bc_kind_e          bc_kind;
   logic              foreign_bc;
   logic              kill;
   logic              clr_all;
   logic [NCORES-1:0] foreign_conf;
   logic              snp_live;
   logic              snp_rset;
   logic              al_set;
   logic              bf_hit;
   logic              bf_ins;
   logic              sticky;

   assign bc_kind      = bc_kind_e'(bc_commit);
   assign foreign_bc   = bc_valid && (bc_core != SELF_ID);
   assign kill         = foreign_bc && (bc_kind == BC_COMMIT) && kmap_o[bc_core];
   assign clr_all      = kill || own_commit;
   assign snp_live     = snp_valid && in_txn;
   assign foreign_conf = snp_live ? (wconf_vec & ~SELF_MASK) : '0;
   assign snp_rset     = snp_read && (|foreign_conf);
   assign al_set       = alloc_valid && in_txn && bf_hit;
   assign bf_ins       = evict_valid && rconf_o[evict_slot];

   kt_map #(.NCORES(NCORES), .CORE_ID(CORE_ID)) u_map (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (clr_all),
      .set_vec    (foreign_conf),
      .drop_valid (foreign_bc && (bc_kind == BC_ABORT_MSG)),
      .drop_core  (bc_core),
      .wconf_sent (sent_wconf),
      .map_q      (kmap_o),
      .sticky_q   (sticky)
   );

   kt_rconf #(.NLINES(NLINES)) u_rconf (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (clr_all),
      .ev_valid (evict_valid),
      .ev_slot  (evict_slot),
      .snp_set  (snp_rset),
      .snp_slot (snp_slot),
      .al_set   (al_set),
      .al_slot  (alloc_slot),
      .bits_q   (rconf_o)
   );

   kt_bloom #(.ADDR_W(ADDR_W), .BITS(BF_BITS), .NHASH(NHASH)) u_bloom (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (clr_all),
      .ins_valid (bf_ins),
      .ins_addr  (evict_addr),
      .q_addr    (alloc_addr),
      .q_hit     (bf_hit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         abort_o     <= 1'b0;
         abort_msg_o <= 1'b0;
         inval_o     <= '0;
      end else begin
         abort_o     <= kill;
         abort_msg_o <= kill && (sticky || sent_wconf);
         inval_o     <= kill ? rconf_o : '0;
      end
   end
endmodule

// File: rtl/kill_tracker_chk.sv
module kill_tracker_chk #(
   parameter int NCORES  = 4,
   parameter int CORE_ID = 0,
   parameter int NLINES  = 16,
   localparam int CID_W  = $clog2(NCORES)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_txn,
   input logic              snp_valid,
   input logic [NCORES-1:0] wconf_vec,
   input logic              bc_valid,
   input logic              bc_commit,
   input logic [CID_W-1:0]  bc_core,
   input logic              own_commit,
   input logic              abort_o,
   input logic              abort_msg_o,
   input logic [NLINES-1:0] inval_o,
   input logic [NCORES-1:0] kmap_o,
   input logic [NLINES-1:0] rconf_o
);
   logic              kill_seen;
   logic [NCORES-1:0] want;

   assign kill_seen = bc_valid && bc_commit && (bc_core != CID_W'(CORE_ID)) && kmap_o[bc_core];
   assign want      = wconf_vec & ~(NCORES'(1) << CORE_ID);

   // R1
   conf_record_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_txn && snp_valid && !kill_seen && !own_commit) |=> ((kmap_o & $past(want)) == $past(want)));
   // R1
   self_bit_chk: assert property (@(posedge clk) disable iff (!rst_n) !kmap_o[CORE_ID]);
   // R4
   kill_abort_chk: assert property (@(posedge clk) disable iff (!rst_n) kill_seen |=> abort_o);
   // R4
   no_stray_abort_chk: assert property (@(posedge clk) disable iff (!rst_n) !kill_seen |=> !abort_o);
   // R5
   abort_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> (kmap_o == '0 && rconf_o == '0));
   // R5
   inval_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_o |-> (inval_o == $past(rconf_o)));
   // R5
   inval_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !abort_o |-> inval_o == '0);
   // R6
   commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      own_commit |=> (kmap_o == '0 && rconf_o == '0));
   // R7
   msg_with_abort_chk: assert property (@(posedge clk) disable iff (!rst_n) abort_msg_o |-> abort_o);
endmodule

bind kill_tracker kill_tracker_chk #(.NCORES(NCORES), .CORE_ID(CORE_ID), .NLINES(NLINES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_txn      (in_txn),
   .snp_valid   (snp_valid),
   .wconf_vec   (wconf_vec),
   .bc_valid    (bc_valid),
   .bc_commit   (bc_commit),
   .bc_core     (bc_core),
   .own_commit  (own_commit),
   .abort_o     (abort_o),
   .abort_msg_o (abort_msg_o),
   .inval_o     (inval_o),
   .kmap_o      (kmap_o),
   .rconf_o     (rconf_o)
);

// File: tb/sim_kill_tracker.sv
module sim_kill_tracker;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_txn = 0, snp_valid = 0, snp_read = 0, sent_wconf = 0;
   logic [3:0]  snp_slot = 0, wconf_vec = 0;
   logic        bc_valid = 0, bc_commit = 0, own_commit = 0;
   logic [1:0]  bc_core = 0;
   logic        evict_valid = 0, alloc_valid = 0;
   logic [3:0]  evict_slot = 0, alloc_slot = 0;
   logic [15:0] evict_addr = 0, alloc_addr = 0;
   logic        abort_o, abort_msg_o;
   logic [15:0] inval_o, rconf_o;
   logic [3:0]  kmap_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   kill_tracker u0 (.*);

   int tests = 0;
   int fails = 0;
   bit compare_on = 0;

   // behavioural reference model (own core number is 0)
   bit       m_km[4];
   bit       m_rc[16];
   bit       m_bf[256];
   bit       m_sticky, m_abort, m_msg;
   bit [15:0] m_inval;

   function automatic int h0(input int a);
      return ((a >> 8) & 255) ^ (a & 255);
   endfunction
   function automatic int h1(input int a);
      int hi;
      hi = (a >> 8) & 255;
      return (a & 255) ^ (((hi << 1) | (hi >> 7)) & 255);
   endfunction

   function automatic logic [3:0] pack_km();
      logic [3:0] v;
      for (int i = 0; i < 4; i++) v[i] = m_km[i];
      return v;
   endfunction
   function automatic logic [15:0] pack_rc();
      logic [15:0] v;
      for (int i = 0; i < 16; i++) v[i] = m_rc[i];
      return v;
   endfunction

   task automatic wipe();
      for (int i = 0; i < 4; i++) m_km[i] = 0;
      for (int i = 0; i < 16; i++) m_rc[i] = 0;
      for (int i = 0; i < 256; i++) m_bf[i] = 0;
      m_sticky = 0;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         wipe();
         m_abort = 0; m_msg = 0; m_inval = 0;
      end else begin
         bit killed, hit, ins;
         int ea;
         killed = bc_valid && bc_commit && bc_core != 0 && m_km[bc_core];
         hit    = m_bf[h0(alloc_addr)] && m_bf[h1(alloc_addr)];
         ins    = evict_valid && m_rc[evict_slot];
         ea     = evict_addr;
         m_abort = killed;
         m_msg   = killed && (m_sticky || sent_wconf);
         m_inval = killed ? pack_rc() : 16'h0;
         if (killed || own_commit) wipe();
         else begin
            bit anyc;
            anyc = 0;
            if (bc_valid && !bc_commit && bc_core != 0) m_km[bc_core] = 0;
            if (snp_valid && in_txn)
               for (int k = 1; k < 4; k++)
                  if (wconf_vec[k]) begin m_km[k] = 1; anyc = 1; end
            if (evict_valid) m_rc[evict_slot] = 0;
            if (anyc && snp_read) m_rc[snp_slot] = 1;
            if (alloc_valid && in_txn && hit) m_rc[alloc_slot] = 1;
            if (ins) begin m_bf[h0(ea)] = 1; m_bf[h1(ea)] = 1; end
            if (sent_wconf) m_sticky = 1;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (compare_on) begin
         chk("R1/R3 kill map", kmap_o, pack_km());
         chk("R2/R8/R9 read-conflict bits", rconf_o, pack_rc());
         chk("R4 abort pulse", abort_o, m_abort);
         chk("R5 invalidate mask", inval_o, m_inval);
         chk("R7 abort message", abort_msg_o, m_msg);
      end
   end

   task automatic idle();
      snp_valid = 0; sent_wconf = 0; bc_valid = 0; own_commit = 0;
      evict_valid = 0; alloc_valid = 0; wconf_vec = 0;
   endtask

   task automatic tick();
      @(negedge clk);
      idle();
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10 reset state
      chk("R10 reset kmap", kmap_o, 0);
      chk("R10 reset rconf", rconf_o, 0);
      chk("R10 reset abort", {abort_o, abort_msg_o, inval_o}, 0);
      compare_on = 1;
      in_txn = 1;

      // reader marks writer core 2 on slot 3, writer commits
      snp_valid = 1; snp_read = 1; snp_slot = 3; wconf_vec = 4'b0100;
      tick();
      chk("R1 writer marked", kmap_o, 4'b0100);
      chk("R2 slot marked", rconf_o, 16'h0008);
      bc_valid = 1; bc_commit = 1; bc_core = 1;     // unmarked committer
      tick();
      chk("R4 unmarked commit ignored", abort_o, 0);
      bc_valid = 1; bc_commit = 1; bc_core = 2;
      tick();
      chk("R4 abort on marked commit", abort_o, 1);
      chk("R5 invalidate slot 3", inval_o, 16'h0008);
      chk("R5 map wiped", kmap_o, 0);
      chk("R7 no message without flag", abort_msg_o, 0);

      // write snoop: map bit only; own bit masked
      snp_valid = 1; snp_read = 0; snp_slot = 5; wconf_vec = 4'b1011;
      tick();
      chk("R1 own bit masked", kmap_o, 4'b1010);
      chk("R2 write snoop no mark", rconf_o, 0);
      // abort message and new conflict for core 3 same cycle; drop core 1
      bc_valid = 1; bc_commit = 0; bc_core = 3;
      snp_valid = 1; snp_read = 0; wconf_vec = 4'b1000;
      tick();
      chk("R3 conflict wins over drop", kmap_o, 4'b1010);
      bc_valid = 1; bc_commit = 0; bc_core = 1;
      tick();
      chk("R3 drop core 1", kmap_o, 4'b1000);
      bc_valid = 1; bc_commit = 1; bc_core = 0;
      tick();
      chk("R3 own id commit ignored", abort_o, 0);

      // commit and killing broadcast together, with sticky flag
      sent_wconf = 1;
      tick();
      bc_valid = 1; bc_commit = 1; bc_core = 3; own_commit = 1;
      tick();
      chk("R6 kill beats commit", abort_o, 1);
      chk("R7 message sent", abort_msg_o, 1);

      // evict marked slot, reallocate, filter hit
      snp_valid = 1; snp_read = 1; snp_slot = 6; wconf_vec = 4'b0010;
      tick();
      evict_valid = 1; evict_slot = 6; evict_addr = 16'h1234;
      tick();
      chk("R8 evict clears mark", rconf_o, 0);
      alloc_valid = 1; alloc_slot = 9; alloc_addr = 16'h1234;
      tick();
      chk("R9 realloc marked", rconf_o, 16'h0200);
      alloc_valid = 1; alloc_slot = 10; alloc_addr = 16'h4321;
      tick();
      chk("R9 miss not marked", rconf_o, 16'h0200);
      in_txn = 0; alloc_valid = 1; alloc_slot = 11; alloc_addr = 16'h1234;
      tick();
      chk("R9 outside txn ignored", rconf_o, 16'h0200);
      in_txn = 1; own_commit = 1;
      tick();
      chk("R6 commit clears", {kmap_o, rconf_o, abort_o}, 0);
      alloc_valid = 1; alloc_slot = 2; alloc_addr = 16'h1234;
      tick();
      chk("R6 filter cleared", rconf_o, 0);

      // random phase against the model
      for (int n = 0; n < 3000; n++) begin
         logic [15:0] pool [8] = '{16'h1234, 16'h0026, 16'hABCD, 16'h00FF,
                                   16'h5A5A, 16'h0100, 16'h7777, 16'hC3C3};
         in_txn      = ($urandom_range(9) != 0);
         snp_valid   = ($urandom_range(3) == 0);
         snp_read    = $urandom_range(1);
         snp_slot    = 4'($urandom_range(15));
         wconf_vec   = ($urandom_range(2) == 0) ? 4'($urandom_range(15)) : 4'h0;
         sent_wconf  = ($urandom_range(19) == 0);
         bc_valid    = ($urandom_range(7) == 0);
         bc_commit   = $urandom_range(1);
         bc_core     = 2'($urandom_range(3));
         own_commit  = ($urandom_range(49) == 0);
         evict_valid = ($urandom_range(5) == 0);
         evict_slot  = 4'($urandom_range(15));
         evict_addr  = pool[$urandom_range(7)];
         alloc_valid = ($urandom_range(4) == 0);
         alloc_slot  = 4'($urandom_range(15));
         alloc_addr  = pool[$urandom_range(7)];
         @(negedge clk);
      end
      idle();
      @(negedge clk);
      compare_on = 0;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule